// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the operands of a memory reference into an address in one pipeline stage. It adds a base register value, an index register value scaled by a power of two, and a sign-extended displacement of selectable size. The result is the segment offset. In segmented mode it then adds a segment base to form the linear address. In flat 64-bit mode the segment base input is ignored and the linear address equals the offset.

In flat mode the block also checks that the linear address is canonical for the implemented virtual address width. It raises a flag when the address is not canonical. In legacy segmented mode both addresses are cut to 32 bits and the flag stays low. The inputs are captured when `in_valid` is high, and the registered results appear one clock later together with `out_valid`.

Top module: `agen_seg_ea`

## Requirements
- R1: In flat mode (`in_flat64`=1) the effective address equals base + (index << scale) + extended displacement, with the sum taken modulo 2^64 and any carry out of bit 63 dropped.
- R2: `in_scale` is a shift amount. Codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8. The index is a two's-complement value, so a negative index lowers the address.
- R3: `in_disp_sz` picks which part of `in_disp` is used, and that part is sign-extended. Code 0 uses bits 7:0, code 1 uses bits 15:0, code 2 uses bits 31:0, and code 3 means no displacement (zero). Bits of `in_disp` above the selected width have no effect.
- R4: In flat mode the linear address equals the effective address, whatever `in_seg_base` holds.
- R5: In legacy mode (`in_flat64`=0) the effective address is the low 32 bits of the R1 sum. The linear address is (segment base + effective address) modulo 2^32. Bits 63:32 of both outputs are zero.
- R6: In flat mode `out_noncanon` is 1 exactly when bits 63 down to VA_W-1 (47 by default) of the linear address are not all equal.
- R7: In legacy mode `out_noncanon` is always 0, even when the base or segment base has high bits set.
- R8: When `in_valid` is high at a rising edge, the results for those inputs appear after that edge, and `out_valid` is high in the same cycle. `out_valid` is never high before that edge.
- R9: When `rst` is high at a rising edge, `out_valid` and all result outputs are cleared to zero, even if `in_valid` is high.
- R10: When `in_valid` is low at a rising edge, `out_valid` goes low and the result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid and are captured at this edge |
| in_flat64 | input | 1 | 1 = flat 64-bit mode, 0 = legacy segmented mode |
| in_base | input | 64 | Base register value |
| in_index | input | 64 | Index register value, two's complement |
| in_scale | input | 2 | Index shift amount, 0 to 3 |
| in_disp | input | 32 | Displacement field |
| in_disp_sz | input | 2 | Displacement size: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = none |
| in_seg_base | input | 64 | Segment base, used only in legacy mode |
| out_valid | output | 1 | Results below are valid |
| out_ea | output | 64 | Effective address (segment offset) |
| out_lin | output | 64 | Linear address |
| out_noncanon | output | 1 | Flat-mode address is not canonical |

## Verification
A wrong internal state shows up at the ports on the cycle right after the capturing edge, because there is only one register stage.

- A fault in the extension or scaling logic changes `out_ea` by a power of two or by a sign-extension step. The table vectors use negative indexes and displacements with junk in their upper bits, so such a fault is visible.
- If the mode is captured wrongly, nonzero upper bits appear in legacy mode, or a segment base leaks into the flat linear address.
- If the canonical window is off by one bit, the flag is wrong on the two vectors that sit just past each canonical boundary.

// File: rtl/ea_pkg.sv
package ea_pkg;

   // Displacement size codes (the encoding is part of the port contract)
   typedef enum logic [1:0] {
      DSZ_B8   = 2'd0,
      DSZ_B16  = 2'd1,
      DSZ_B32  = 2'd2,
      DSZ_NONE = 2'd3
   } disp_sz_e;

   localparam int unsigned SCALE_CODE_W = 2;
   localparam int unsigned SCALE_WAYS   = 1 << SCALE_CODE_W;

endpackage

// File: rtl/ea_disp_sext.sv
module ea_disp_sext
   import ea_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DISP_W = 32
) (
   input  logic [DISP_W-1:0] disp_i,
   input  disp_sz_e          sz_i,
   output logic [ADDR_W-1:0] disp_ext_o
);

   localparam int unsigned PAD8  = ADDR_W - 8;
   localparam int unsigned PAD16 = ADDR_W - 16;
   localparam int unsigned PAD32 = ADDR_W - 32;

   // Elaboration-time parameter checks
   if (DISP_W != 32) begin : g_bad_disp
      $error("ea_disp_sext: DISP_W must be 32");
   end
   if (ADDR_W < 32) begin : g_bad_addr
      $error("ea_disp_sext: ADDR_W must be at least 32");
   end

   logic [ADDR_W-1:0] ext8, ext16, ext32;

   assign ext8  = {{PAD8{disp_i[7]}},   disp_i[7:0]};
   assign ext16 = {{PAD16{disp_i[15]}}, disp_i[15:0]};
   assign ext32 = {{PAD32{disp_i[31]}}, disp_i[31:0]};

   always_comb begin
      unique case (sz_i)
         DSZ_B8:   disp_ext_o = ext8;
         DSZ_B16:  disp_ext_o = ext16;
         DSZ_B32:  disp_ext_o = ext32;
         default:  disp_ext_o = '0;
      endcase
   end

endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale
   import ea_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter bit          MUX_SHIFT = 1'b1
) (
   input  logic [ADDR_W-1:0]       index_i,
   input  logic [SCALE_CODE_W-1:0] scale_i,
   output logic [ADDR_W-1:0]       scaled_o
);

   if (MUX_SHIFT) begin : g_mux
      // Pre-shifted copies selected by a 4-way mux: one mux level of depth
      logic [ADDR_W-1:0] cand [SCALE_WAYS];
      for (genvar k = 0; k < SCALE_WAYS; k++) begin : g_cand
         assign cand[k] = index_i << k;
      end
      assign scaled_o = cand[scale_i];
   end else begin : g_barrel
      assign scaled_o = index_i << scale_i;
   end

endmodule

// File: rtl/ea_sum3.sv
module ea_sum3 #(
   parameter int unsigned ADDR_W  = 64,
   parameter bit          USE_CSA = 1'b1
) (
   input  logic [ADDR_W-1:0] a_i,
   input  logic [ADDR_W-1:0] b_i,
   input  logic [ADDR_W-1:0] c_i,
   output logic [ADDR_W-1:0] sum_o
);

   if (USE_CSA) begin : g_csa
      // One carry-save row, then a single carry-propagate adder
      logic [ADDR_W-1:0] s_vec, c_vec, c_shift;
      assign s_vec   = a_i ^ b_i ^ c_i;
      assign c_vec   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
      assign c_shift = {c_vec[ADDR_W-2:0], 1'b0};
      assign sum_o   = s_vec + c_shift;
   end else begin : g_chain
      assign sum_o = a_i + b_i + c_i;
   end

endmodule

// File: rtl/ea_canon_chk.sv
module ea_canon_chk #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned VA_W   = 48,
   localparam int unsigned HI_W  = (VA_W < ADDR_W) ? (ADDR_W - VA_W + 1) : 1
) (
   input  logic            en_i,
   input  logic [HI_W-1:0] hi_i,
   output logic            noncanon_o
);

   // Elaboration-time parameter checks
   if (VA_W < 2 || VA_W > ADDR_W) begin : g_bad_va
      $error("ea_canon_chk: VA_W must lie in 2..ADDR_W");
   end

   if (VA_W < ADDR_W) begin : g_chk
      logic all_one, all_zero;
      assign all_one    = &hi_i;
      assign all_zero   = ~|hi_i;
      assign noncanon_o = en_i & ~(all_one | all_zero);
   end else begin : g_full
      // The full width is implemented, so every address is canonical
      logic unused_hi;
      assign unused_hi  = ^{hi_i, en_i};
      assign noncanon_o = 1'b0;
   end

endmodule

// File: rtl/agen_seg_ea.sv
module agen_seg_ea
   import ea_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned VA_W      = 48,
   parameter int unsigned DISP_W    = 32,
   parameter int unsigned LEGACY_W  = 32,
   parameter bit          USE_CSA   = 1'b1,
   parameter bit          MUX_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_flat64,
   input  logic [63:0]       in_base,
   input  logic [63:0]       in_index,
   input  logic [1:0]        in_scale,
   input  logic [31:0]       in_disp,
   input  logic [1:0]        in_disp_sz,
   input  logic [63:0]       in_seg_base,
   output logic              out_valid,
   output logic [63:0]       out_ea,
   output logic [63:0]       out_lin,
   output logic              out_noncanon
);

   localparam int unsigned UPPER_W = ADDR_W - LEGACY_W;
   localparam int unsigned HI_W    = (VA_W < ADDR_W) ? (ADDR_W - VA_W + 1) : 1;
   localparam int unsigned HI_LSB  = (VA_W < ADDR_W) ? (VA_W - 1) : (ADDR_W - 1);

   // Elaboration-time parameter checks
   if (ADDR_W != 64) begin : g_bad_addr
      $error("agen_seg_ea: ADDR_W must be 64 to match the port widths");
   end
   if (LEGACY_W == 0 || LEGACY_W >= ADDR_W) begin : g_bad_leg
      $error("agen_seg_ea: LEGACY_W must lie in 1..ADDR_W-1");
   end
   if (VA_W < LEGACY_W) begin : g_bad_va
      $error("agen_seg_ea: VA_W must not be below LEGACY_W");
   end

   // ---------------- operand preparation ----------------
   logic [ADDR_W-1:0] disp_ext, idx_scaled, ea_full;
   logic [ADDR_W-1:0] ea_sel, seg_eff, lin_full, lin_sel;
   logic [HI_W-1:0]   lin_hi;
   logic              noncanon_c;

   ea_disp_sext #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) u_disp (
      .disp_i     (in_disp),
      .sz_i       (disp_sz_e'(in_disp_sz)),
      .disp_ext_o (disp_ext)
   );

   ea_index_scale #(
      .ADDR_W    (ADDR_W),
      .MUX_SHIFT (MUX_SHIFT)
   ) u_scale (
      .index_i  (in_index),
      .scale_i  (in_scale),
      .scaled_o (idx_scaled)
   );

   ea_sum3 #(
      .ADDR_W  (ADDR_W),
      .USE_CSA (USE_CSA)
   ) u_sum (
      .a_i   (in_base),
      .b_i   (idx_scaled),
      .c_i   (disp_ext),
      .sum_o (ea_full)
   );

   // ---------------- mode handling ----------------
   always_comb begin
      if (in_flat64) begin
         ea_sel  = ea_full;
         seg_eff = '0;
      end else begin
         ea_sel  = {{UPPER_W{1'b0}}, ea_full[LEGACY_W-1:0]};
         seg_eff = in_seg_base;
      end
   end

   assign lin_full = seg_eff + ea_sel;

   always_comb begin
      if (in_flat64) lin_sel = lin_full;
      else           lin_sel = {{UPPER_W{1'b0}}, lin_full[LEGACY_W-1:0]};
   end

   assign lin_hi = lin_sel[ADDR_W-1:HI_LSB];

   ea_canon_chk #(
      .ADDR_W (ADDR_W),
      .VA_W   (VA_W)
   ) u_canon (
      .en_i       (in_flat64),
      .hi_i       (lin_hi),
      .noncanon_o (noncanon_c)
   );

   // ---------------- pipeline register ----------------
   logic mode_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_ea       <= '0;
         out_lin      <= '0;
         out_noncanon <= 1'b0;
         mode_q       <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_ea       <= ea_sel;
            out_lin      <= lin_sel;
            out_noncanon <= noncanon_c;
            mode_q       <= in_flat64;
         end
      end
   end

   // ---------------- assertions ----------------
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));                    // R8

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_ea == '0 && out_lin == '0));      // R9

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(in_valid)) |->
         ($stable(out_ea) && $stable(out_lin) && $stable(out_noncanon))); // R10

   AST_FLAT_LIN_EQ_EA: assert property (@(posedge clk) disable iff (rst)
      (out_valid && mode_q) |-> (out_lin == out_ea));                     // R4

   AST_LEGACY_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !mode_q) |->
         (out_ea[ADDR_W-1:LEGACY_W] == '0 && out_lin[ADDR_W-1:LEGACY_W] == '0)); // R5

   AST_LEGACY_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !mode_q) |-> !out_noncanon);                          // R7

   if (VA_W < ADDR_W) begin : g_canon_ast
      AST_CANON_FLAG: assert property (@(posedge clk) disable iff (rst)
         (out_valid && mode_q) |->
            (out_noncanon == !((&out_lin[ADDR_W-1:VA_W-1]) ||
                               (~|out_lin[ADDR_W-1:VA_W-1]))));           // R6
   end

endmodule

// File: tb/agen_seg_ea_tb_top.sv
module agen_seg_ea_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_flat64 = 1'b0;
   logic [63:0] in_base = '0;
   logic [63:0] in_index = '0;
   logic [1:0]  in_scale = '0;
   logic [31:0] in_disp = '0;
   logic [1:0]  in_disp_sz = '0;
   logic [63:0] in_seg_base = '0;
   logic        out_valid;
   logic [63:0] out_ea, out_lin;
   logic        out_noncanon;

   int n_total = 0;
   int n_bad   = 0;

   always #5 clk = ~clk;

   agen_seg_ea dut_i (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_flat64    (in_flat64),
      .in_base      (in_base),
      .in_index     (in_index),
      .in_scale     (in_scale),
      .in_disp      (in_disp),
      .in_disp_sz   (in_disp_sz),
      .in_seg_base  (in_seg_base),
      .out_valid    (out_valid),
      .out_ea       (out_ea),
      .out_lin      (out_lin),
      .out_noncanon (out_noncanon)
   );

   typedef struct packed {
      logic        flat;
      logic [1:0]  scale;
      logic [1:0]  dsz;
      logic [63:0] base;
      logic [63:0] idx;
      logic [31:0] disp;
      logic [63:0] seg;
      logic [63:0] exp_ea;
      logic [63:0] exp_lin;
      logic        exp_nc;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      // R1 R4: plain sum, segment base ignored in flat mode
      '{1'b1, 2'd0, 2'd2, 64'h1000, 64'h10, 32'h20, 64'hDEAD_BEEF_0000_1111,
        64'h1030, 64'h1030, 1'b0},
      // R2 R3: index -1 scaled by 8, 8-bit displacement 0xF0 = -16
      '{1'b1, 2'd3, 2'd0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_00F0, 64'h0,
        64'h0FE8, 64'h0FE8, 1'b0},
      // R2 R3: scale 4, 16-bit displacement -0x8000, upper disp bits junk
      '{1'b1, 2'd2, 2'd1, 64'h2000, 64'h3, 32'hABCD_8000, 64'h55,
        64'hFFFF_FFFF_FFFF_A00C, 64'hFFFF_FFFF_FFFF_A00C, 1'b0},
      // R3 R6: no displacement, highest low canonical address
      '{1'b1, 2'd1, 2'd3, 64'h0000_7FFF_FFFF_FFFF, 64'h0, 32'h1234, 64'h77,
        64'h0000_7FFF_FFFF_FFFF, 64'h0000_7FFF_FFFF_FFFF, 1'b0},
      // R6: one past the low canonical half
      '{1'b1, 2'd0, 2'd0, 64'h0000_7FFF_FFFF_FFFF, 64'h1, 32'h0, 64'h0,
        64'h0000_8000_0000_0000, 64'h0000_8000_0000_0000, 1'b1},
      // R6: one below the high canonical half
      '{1'b1, 2'd0, 2'd2, 64'hFFFF_8000_0000_0000, 64'h0, 32'hFFFF_FFFF, 64'h0,
        64'hFFFF_7FFF_FFFF_FFFF, 64'hFFFF_7FFF_FFFF_FFFF, 1'b1},
      // R1: wrap through 2^64
      '{1'b1, 2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 32'h0, 64'h0,
        64'h0, 64'h0, 1'b0},
      // R5 R7: legacy truncation, segment add wraps at 2^32
      '{1'b0, 2'd1, 2'd2, 64'h0000_0001_8000_0000, 64'h4000_0000, 32'h10,
        64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 64'h8, 1'b0},
      // R5 R7: legacy with high junk in base, no canonical flag
      '{1'b0, 2'd0, 2'd0, 64'h1234_5678_0000_0100, 64'h0, 32'h80,
        64'h0000_0000_1000_0000, 64'h80, 64'h1000_0080, 1'b0}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v, input logic vld);
      in_valid    = vld;
      in_flat64   = v.flat;
      in_scale    = v.scale;
      in_disp_sz  = v.dsz;
      in_base     = v.base;
      in_index    = v.idx;
      in_disp     = v.disp;
      in_seg_base = v.seg;
   endtask

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_total++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 out_valid after reset", {63'b0, out_valid}, 64'h0);
      chk("R9 out_ea after reset", out_ea, 64'h0);
      rst = 1'b0;
      @(negedge clk);

      // R8: nothing before the capturing edge, results right after it
      apply(VEC[0], 1'b1);
      #1;
      chk("R8 out_valid before edge", {63'b0, out_valid}, 64'h0);
      @(negedge clk);
      chk("R8 out_valid after edge", {63'b0, out_valid}, 64'h1);

      // Table walk, back to back
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i], 1'b1);
         @(negedge clk);
         chk($sformatf("R1-table vec%0d out_valid R8", i), {63'b0, out_valid}, 64'h1);
         chk($sformatf("vec%0d out_ea R1/R2/R3/R5", i), out_ea, VEC[i].exp_ea);
         chk($sformatf("vec%0d out_lin R4/R5", i), out_lin, VEC[i].exp_lin);
         chk($sformatf("vec%0d out_noncanon R6/R7", i), {63'b0, out_noncanon},
             {63'b0, VEC[i].exp_nc});
      end

      // R10: idle cycle with changed inputs keeps results
      apply(VEC[4], 1'b0);
      @(negedge clk);
      chk("R10 out_valid low when idle", {63'b0, out_valid}, 64'h0);
      chk("R10 out_ea held", out_ea, 64'h80);
      chk("R10 out_lin held", out_lin, 64'h1000_0080);
      chk("R10 out_noncanon held", {63'b0, out_noncanon}, 64'h0);

      // R9: reset overrides a valid input
      apply(VEC[4], 1'b1);
      @(negedge clk);
      chk("R6 flag set before reset", {63'b0, out_noncanon}, 64'h1);
      rst = 1'b1;
      @(negedge clk);
      chk("R9 out_valid cleared", {63'b0, out_valid}, 64'h0);
      chk("R9 out_lin cleared", out_lin, 64'h0);
      chk("R9 out_noncanon cleared", {63'b0, out_noncanon}, 64'h0);
      rst = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

endmodule